// File: doc/BRIEF.md
# Keypad Status Register Conditioner

This block turns a bus of raw button levels into the 16-bit key status word that software reads. The buttons arrive active-high (1 = held). They first pass through a two-flop synchronizer. A direction filter then removes pairs of opposing directions that cannot physically be held at once, and the result is inverted into active-low form. Bits that hold no key read as zero.

The filter works on two pairs. Key bits 4 and 5 form the right/left pair, and key bits 6 and 7 form the up/down pair. When both keys of a pair are held and the allow input is low, both keys of that pair are reported as released. When the allow input is high, the filter passes every key unchanged. The other keys (bits 0 to 3, 8 and 9) never go through the filter. The allow input is a static configuration level. It acts on the read value without any clock delay. The raw keys, by contrast, reach the read value two clocks after they change.

Top module: `keypad_status_cond`

## Requirements
- R1: While reset is applied and after it is released with no key held, rd_data reads 16'h03FF.
- R2: For a held mask P after filtering, rd_data[9:0] equals P XOR 10'h3FF, so a held key reads 0 and a released key reads 1.
- R3: A change on keys_raw is first visible on rd_data after the second rising clock edge that samples it. It is not visible after only one edge.
- R4: When allow_opposing is 0 and key bits 4 and 5 are both held, rd_data bits 5 and 4 both read 1 (released).
- R5: When allow_opposing is 0 and key bits 6 and 7 are both held, rd_data bits 7 and 6 both read 1 (released).
- R6: When allow_opposing is 1, held opposing keys are reported as held (read 0), the same as any other key.
- R7: Key bits 0-3, 8 and 9 are reported the same way whatever the state of the filter or of the direction keys.
- R8: rd_data[15:10] always reads 0.
- R9: A single held direction key whose partner is released is reported as held (reads 0) whatever the value of allow_opposing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the synchronizer to no key held |
| keys_raw | input | 10 | Raw button levels, active-high, asynchronous to clk |
| allow_opposing | input | 1 | 1 = report opposing direction pairs as held; 0 = cancel them |
| rd_data | output | 16 | Key status word: bits 9:0 active-low keys, bits 15:10 zero |

## Verification
The main function is tried with several kinds of pattern. Single keys in each position show that the inversion and the bit order are right. Each opposing pair is held on its own and then both pairs together, with allow low and then high. This separates cancelling the right/left pair from cancelling the up/down pair, and shows that the allow input overrides the filter. Patterns that combine every non-direction key with opposing pairs show that the filter does not disturb bits outside the pairs. A long sweep of mixed masks, with allow toggled, checks the two-cycle delay on every cycle against a reference model.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

    localparam int KEY_W       = 10;
    localparam int REG_W       = 16;
    localparam int PAD_W       = REG_W - KEY_W;
    localparam int NUM_PAIRS   = 2;
    localparam int DIR_BASE    = 4;
    localparam int SYNC_STAGES = 2;

    typedef logic [KEY_W-1:0] key_vec_t;

    typedef struct packed {
        logic [PAD_W-1:0] pad;
        key_vec_t         keys_n;
    } status_word_t;

    localparam key_vec_t IDLE_MASK = {KEY_W{1'b1}};

    // low bit of opposing pair p: pair 0 = right/left, pair 1 = up/down
    function automatic int pair_lo(input int p);
        return DIR_BASE + 2 * p;
    endfunction

    function automatic key_vec_t dir_mask();
        key_vec_t m;
        m = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            m[pair_lo(p)]     = 1'b1;
            m[pair_lo(p) + 1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/keypad_sync.sv
module keypad_sync
    import keypad_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  key_vec_t din,
    output key_vec_t dout
);

    key_vec_t stage_q [STAGES];
    logic     seen_clk_q;

    always_ff @(posedge clk) begin
        if (rst) seen_clk_q <= 1'b0;
        else     seen_clk_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    // R3: first stage takes the raw input on each edge
    a_r3_first_stage: assert property (@(posedge clk) disable iff (rst)
        seen_clk_q |-> stage_q[0] == $past(din));

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_q[i-1];
        end

        // R3: each later stage holds the previous stage one clock later
        a_r3_chain: assert property (@(posedge clk) disable iff (rst)
            seen_clk_q |-> stage_q[i] == $past(stage_q[i-1]));
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/keypad_filter.sv
module keypad_filter
    import keypad_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_vec_t held_in,
    input  logic     allow_opposing,
    output key_vec_t held_out
);

    localparam key_vec_t DIRS = dir_mask();

    always_comb begin
        held_out = held_in;
        if (!allow_opposing) begin
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (held_in[pair_lo(p)] && held_in[pair_lo(p) + 1]) begin
                    held_out[pair_lo(p)]     = 1'b0;
                    held_out[pair_lo(p) + 1] = 1'b0;
                end
            end
        end
    end

    // R4, R5: with the filter on, no pair leaves with both keys held
    a_r4_r5_no_opposing: assert property (@(posedge clk) disable iff (rst)
        !allow_opposing |-> !(held_out[4] && held_out[5]) && !(held_out[6] && held_out[7]));

    // R6: with the filter off, the mask passes unchanged
    a_r6_transparent: assert property (@(posedge clk) disable iff (rst)
        allow_opposing |-> held_out == held_in);

    // R7: non-direction keys are never touched
    a_r7_fixed_keys: assert property (@(posedge clk) disable iff (rst)
        (held_out & ~DIRS) == (held_in & ~DIRS));

    // R9: a lone direction key in the right/left pair survives
    a_r9_single_kept: assert property (@(posedge clk) disable iff (rst)
        !(held_in[4] && held_in[5]) |-> held_out[5:4] == held_in[5:4]);

endmodule

// File: rtl/keypad_format.sv
module keypad_format
    import keypad_pkg::*;
(
    input  key_vec_t     held,
    output status_word_t word
);

    always_comb begin
        word.pad    = '0;
        word.keys_n = held ^ IDLE_MASK;
    end

endmodule

// File: rtl/keypad_status_cond.sv
module keypad_status_cond
    import keypad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [KEY_W-1:0]  keys_raw,
    input  logic              allow_opposing,
    output logic [REG_W-1:0]  rd_data
);

    key_vec_t     synced;
    key_vec_t     filtered;
    status_word_t word;

    keypad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (keys_raw),
        .dout (synced)
    );

    keypad_filter u_filter (
        .clk            (clk),
        .rst            (rst),
        .held_in        (synced),
        .allow_opposing (allow_opposing),
        .held_out       (filtered)
    );

    keypad_format u_format (
        .held (filtered),
        .word (word)
    );

    assign rd_data = word;

endmodule

// File: tb/keypad_status_cond_bench.sv
module keypad_status_cond_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  keys_raw = '0;
    logic        allow_opposing = 1'b0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [9:0] hist[$];
    bit         rst_hist[$];

    always #2.5 clk = ~clk;

    keypad_status_cond u_keypad_status_cond (
        .clk            (clk),
        .rst            (rst),
        .keys_raw       (keys_raw),
        .allow_opposing (allow_opposing),
        .rd_data        (rd_data)
    );

    function automatic logic [15:0] model(input logic [9:0] held, input logic al);
        logic [9:0] m = held;
        if (!al && m[4] && m[5]) begin m[4] = 1'b0; m[5] = 1'b0; end
        if (!al && m[6] && m[7]) begin m[6] = 1'b0; m[7] = 1'b0; end
        return {6'b0, m ^ 10'h3FF};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive after a falling edge, sample at the next falling edge
    task automatic cyc(input logic [9:0] raw, input logic al, input string tag);
        logic [9:0] held;
        keys_raw       = raw;
        allow_opposing = al;
        @(posedge clk);
        hist.push_back(rst ? 10'h0 : keys_raw);
        rst_hist.push_back(rst);
        @(negedge clk);
        if (hist.size() >= 2) begin
            held = rst_hist[$] ? 10'h0 : hist[$-1];
            check(tag, rd_data, model(held, allow_opposing));
            check("R8", {10'h0, rd_data[15:10]}, 16'h0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) cyc(10'h155, 1'b0, "R1");
        rst = 1'b0;
        cyc(10'h000, 1'b0, "R1");
        cyc(10'h000, 1'b0, "R1");
        check("R1", rd_data, 16'h03FF);

        // R3: one edge is not enough, two are
        keys_raw = 10'h001;
        @(posedge clk); hist.push_back(keys_raw); rst_hist.push_back(1'b0);
        @(negedge clk);
        check("R3", rd_data, 16'h03FF);
        cyc(10'h001, 1'b0, "R3");
        check("R3", rd_data, 16'h03FE);

        for (int b = 0; b < 10; b++) begin
            cyc(10'(1 << b), 1'b0, "R2");
            cyc(10'(1 << b), 1'b0, "R2");
        end
        cyc(10'h000, 1'b0, "R2");

        cyc(10'h030, 1'b0, "R4"); cyc(10'h030, 1'b0, "R4");
        check("R4", rd_data, 16'h03FF);
        cyc(10'h0C0, 1'b0, "R5"); cyc(10'h0C0, 1'b0, "R5");
        check("R5", rd_data, 16'h03FF);
        cyc(10'h0F0, 1'b1, "R6"); cyc(10'h0F0, 1'b1, "R6");
        check("R6", rd_data, 16'h030F);
        cyc(10'h0F0, 1'b0, "R6");
        check("R6", rd_data, 16'h03FF);
        cyc(10'h3FF, 1'b0, "R7"); cyc(10'h3FF, 1'b0, "R7");
        check("R7", rd_data, 16'h00F0);
        cyc(10'h30F, 1'b1, "R7"); cyc(10'h30F, 1'b1, "R7");
        check("R7", rd_data, 16'h00F0);
        cyc(10'h050, 1'b0, "R9"); cyc(10'h050, 1'b0, "R9");
        check("R9", rd_data, 16'h03AF);
        cyc(10'h0A0, 1'b1, "R9"); cyc(10'h0A0, 1'b1, "R9");
        check("R9", rd_data, 16'h035F);
        cyc(10'h070, 1'b0, "R9"); cyc(10'h070, 1'b0, "R9");
        check("R9", rd_data, 16'h03BF);

        for (int i = 0; i < 300; i++)
            cyc(10'((i * 37 + 11) % 1024), 1'((i / 7) % 2), "R2");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule